// File: doc/BRIEF.md
# Network Controller Interrupt Status Unit

This unit gathers single-cycle event pulses from the receive path, the transmit path and the host bus interface of a network controller. Each pulse sets a sticky bit in a 26-bit status word. Software reaches the unit over a small register bus. The bus gives access to a status word that clears itself when read, a per-bit mask and a one-bit global enable. A single level-sensitive interrupt request goes to the host.

The ten upper status bits hold serious conditions: bus aborts, parity and system errors, status FIFO overrun, and reset-complete notices. Bit 15 of the status word is computed rather than stored. It reads as the OR of bits 25 down to 16, so a handler can test one bit to learn whether any of that group fired. The descriptor-done events for receive and transmit are only recorded when the descriptor that completed carried its interrupt-request flag. That flag arrives next to the event pulse.

Register offsets on the bus are fixed: status at 0x10, mask at 0x14 and enable at 0x18. Bus reads return their data one clock after the request.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, `irq_o` is 0, and the status (0x10), mask (0x14) and enable (0x18) registers all read as zero.
- R2: A one-cycle pulse on `evt_i[n]` sets status bit n, for n in 0..14, 16 and 20..25. A bus read issued in cycle k returns the register value on `bus_rdata` from cycle k+1 onward.
- R3: A read of the status offset 0x10 clears every latched status bit, so an immediate second read returns zero.
- R4: Status read bit 15 equals the OR of status bits 25..16. It is 1 when any of those bits is set and 0 otherwise.
- R5: Status bits 17, 18 and 19 always read 0. A pulse on `evt_i[15]` does not set bit 15 by itself.
- R6: The receive descriptor-done event (`evt_i[1]`) sets status bit 1 only if `rx_dflag_i` is high in the same cycle. The transmit descriptor-done event (`evt_i[7]`) sets status bit 7 only if `tx_dflag_i` is high in the same cycle.
- R7: The mask register (0x14) stores bits 25..0 of a write and reads them back. The enable register (0x18) stores only bit 0 of a write. All other bits of both registers read as 0.
- R8: `irq_o` is 1 only when enable bit 0 is set and at least one status bit (bit 15 included, as its read value) is 1 while its mask bit is also 1.
- R9: `irq_o` rises one clock after the status bit that causes it is latched. It falls one clock after the clearing read takes effect.
- R10: If an event arrives in the same cycle as a status read, the read does not return it. The event stays latched and the next read returns it.
- R11: Writes to the status offset have no effect on the status register.
- R12: Latched status bits stay set across any number of cycles without a status read, and new events add to the bits already held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| evt_i | input | 26 | Event pulses, one per status bit |
| rx_dflag_i | input | 1 | Receive descriptor interrupt-request flag |
| tx_dflag_i | input | 1 | Transmit descriptor interrupt-request flag |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
An event pulse applied before clock edge k is in the status register after edge k. It can raise `irq_o` only after edge k+1. A read requested before edge k shows its data on `bus_rdata` after that same edge, and the clear it causes takes effect at that edge. The bench drives and samples on the falling edge, so every check lands half a cycle after the rising edge that produces the result. For timing-sensitive checks the bench also samples one edge early, which confirms that a result is neither too early nor too late.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int STAT_W = 26;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int SUM_BIT = 15;
  localparam int HI_LO = 16;
  localparam int RXD_BIT = 1;
  localparam int TXD_BIT = 7;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_ENAB = 8'h18;
  // bits that a pulse may set: 0..14, 16, 20..25
  localparam logic [STAT_W-1:0] LATCH_OK = 26'h3F1_7FFF;
endpackage

// File: rtl/irq_event_latch.sv
module irq_event_latch
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              rx_dflag_i,
  input  logic              tx_dflag_i,
  input  logic              clr_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] gated;
  logic [STAT_W-1:0] stat_q;

  always_comb begin
    gated = evt_i & LATCH_OK;
    gated[RXD_BIT] = evt_i[RXD_BIT] & rx_dflag_i;
    gated[TXD_BIT] = evt_i[TXD_BIT] & tx_dflag_i;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else if (clr_i) stat_q <= gated;
    else stat_q <= stat_q | gated;
  end

  assign stat_o = stat_q;

  p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_i && evt_i == '0) |=> stat_q == '0);
  p_reserved_r5: assert property (@(posedge clk) disable iff (rst)
    stat_q[19:17] == 3'b000 && stat_q[SUM_BIT] == 1'b0);
  p_rxdesc_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !rx_dflag_i) |=> !stat_q[RXD_BIT]);
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [STAT_W-1:0] stat_view_i,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [STAT_W-1:0] mask_o,
  output logic              en_o,
  output logic              clr_o
);
  localparam int PAD_W = DATA_W - STAT_W;
  logic [STAT_W-1:0] mask_q;
  logic              en_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rmux;
  logic              rd;

  assign rd    = bus_sel && !bus_wr;
  assign clr_o = rd && (bus_addr == OFS_STAT);

  always_comb begin
    unique case (bus_addr)
      OFS_STAT: rmux = {{PAD_W{1'b0}}, stat_view_i};
      OFS_MASK: rmux = {{PAD_W{1'b0}}, mask_q};
      OFS_ENAB: rmux = {{(DATA_W-1){1'b0}}, en_q};
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      en_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (bus_sel && bus_wr && bus_addr == OFS_MASK) mask_q <= bus_wdata[STAT_W-1:0];
      if (bus_sel && bus_wr && bus_addr == OFS_ENAB) en_q <= bus_wdata[0];
      if (rd) rdata_q <= rmux;
    end
  end

  assign bus_rdata = rdata_q;
  assign mask_o    = mask_q;
  assign en_o      = en_q;

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_wr) |=> $stable(mask_q) && $stable(en_q));
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] stat_view_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic              en_i,
  output logic              irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else irq_q <= en_i && |(stat_view_i & mask_i);
  end

  assign irq_o = irq_q;

  p_irq_enable_r8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !irq_q);
  p_irq_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (stat_view_i == '0) |=> !irq_q);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              rx_dflag_i,
  input  logic              tx_dflag_i,
  output logic              irq_o
);
  logic [STAT_W-1:0] stat_raw, stat_view, mask;
  logic              en, clr;

  irq_event_latch u_latch (
    .clk(clk), .rst(rst), .evt_i(evt_i), .rx_dflag_i(rx_dflag_i),
    .tx_dflag_i(tx_dflag_i), .clr_i(clr), .stat_o(stat_raw)
  );

  // bit 15 summarises the upper error group
  always_comb begin
    stat_view = stat_raw;
    stat_view[SUM_BIT] = |stat_raw[STAT_W-1:HI_LO];
  end

  irq_reg_file u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat_view_i(stat_view),
    .bus_rdata(bus_rdata), .mask_o(mask), .en_o(en), .clr_o(clr)
  );

  irq_req_gen u_req (
    .clk(clk), .rst(rst), .stat_view_i(stat_view), .mask_i(mask),
    .en_i(en), .irq_o(irq_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !irq_o);
endmodule

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [25:0] evt_i = '0;
  logic        rx_dflag_i = 1'b0, tx_dflag_i = 1'b0;
  logic        irq_o;
  int n_chk = 0, n_bad = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  irq_status_unit uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic pulse(input logic [25:0] e, input logic rf, input logic tf);
    evt_i = e; rx_dflag_i = rf; tx_dflag_i = tf;
    @(negedge clk);
    evt_i = '0; rx_dflag_i = 0; tx_dflag_i = 0;
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'd0, irq_o}, 0);
    rd(8'h10, rv); chk("R1 status", rv, 0);
    rd(8'h14, rv); chk("R1 mask", rv, 0);
    rd(8'h18, rv); chk("R1 enable", rv, 0);
  endtask

  task automatic t_latch_clear;
    pulse(26'h1, 0, 0);
    pulse(26'h40, 0, 0);
    repeat (3) @(negedge clk);
    rd(8'h10, rv); chk("R2/R12 latched", rv, 32'h41);
    rd(8'h10, rv); chk("R3 cleared", rv, 0);
  endtask

  task automatic t_summary;
    pulse(26'h40_0000, 0, 0);
    rd(8'h10, rv); chk("R4 summary set", rv, 32'h40_8000);
    pulse(26'h2000, 0, 0);
    rd(8'h10, rv); chk("R4 summary clear", rv, 32'h2000);
    pulse(26'h3FF_8000, 0, 0);
    rd(8'h10, rv); chk("R5 reserved", rv, 32'h3F1_8000);
    pulse(26'h8000, 0, 0);
    rd(8'h10, rv); chk("R5 bit15 input", rv, 0);
  endtask

  task automatic t_desc;
    pulse(26'h82, 0, 0);
    rd(8'h10, rv); chk("R6 no flag", rv, 0);
    pulse(26'h82, 1, 0);
    rd(8'h10, rv); chk("R6 rx flag", rv, 32'h2);
    pulse(26'h82, 0, 1);
    rd(8'h10, rv); chk("R6 tx flag", rv, 32'h80);
  endtask

  task automatic t_regs;
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, rv); chk("R7 mask", rv, 32'h3FF_FFFF);
    wr(8'h18, 32'hFFFF_FFFE);
    rd(8'h18, rv); chk("R7 enable bit0 only", rv, 0);
    wr(8'h14, 32'h0000_0400);
    rd(8'h14, rv); chk("R7 mask value", rv, 32'h400);
  endtask

  task automatic t_irq;
    pulse(26'h400, 0, 0);
    @(negedge clk);
    chk("R8 no enable", {31'd0, irq_o}, 0);
    wr(8'h18, 32'h1);
    chk("R9 not early", {31'd0, irq_o}, 0);
    @(negedge clk);
    chk("R8 raised", {31'd0, irq_o}, 1);
    rd(8'h10, rv); chk("R2 read", rv, 32'h400);
    chk("R9 still high", {31'd0, irq_o}, 1);
    @(negedge clk);
    chk("R9 dropped", {31'd0, irq_o}, 0);
    pulse(26'h1, 0, 0);
    @(negedge clk);
    chk("R8 unmasked bit", {31'd0, irq_o}, 0);
    rd(8'h10, rv);
    wr(8'h14, 32'h8000);
    pulse(26'h20_0000, 0, 0);
    chk("R9 one cycle later", {31'd0, irq_o}, 0);
    @(negedge clk);
    chk("R8 summary mask", {31'd0, irq_o}, 1);
    rd(8'h10, rv);
    wr(8'h18, 32'h0);
  endtask

  task automatic t_same_cycle;
    pulse(26'h1, 0, 0);
    bus_sel = 1; bus_wr = 0; bus_addr = 8'h10; evt_i = 26'h100;
    @(negedge clk);
    bus_sel = 0; evt_i = '0;
    chk("R10 first read", bus_rdata, 32'h1);
    rd(8'h10, rv); chk("R10 kept", rv, 32'h100);
  endtask

  task automatic t_wr_status;
    pulse(26'h4, 0, 0);
    wr(8'h10, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, rv); chk("R11 write ignored", rv, 32'h4);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset; t_latch_clear; t_summary; t_desc;
        t_regs; t_irq; t_same_cycle; t_wr_status;
      end
      begin
        repeat (5000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule